// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog that sits on a simple 32-bit register bus. It holds a 64-bit count-up counter and a 64-bit period, each split into a lower and an upper 32-bit word. The counter runs only when all three of these hold. The global control register selects the watchdog mode. Both counter halves are released. Software has armed the watchdog through a two-key handshake. If the counter reaches the period, the block raises a reset request pulse and latches a timeout flag.

Software first sets a sticky enable bit. It then writes the first key and the second key, in that order, into the key field of the control register. Once the watchdog is active, the same pair written again restarts the count from zero. Any other key value written while active trips the reset at once. While active, the counter, the period and the global control register are locked against writes, so the watchdog cannot be disarmed by reprogramming it.

Top module: `wdt_top`

## Requirements
- R1: After reset, `wd_rst_req` is low and every readable register (counter words 0x10/0x14, period words 0x18/0x1C, global control 0x24, watchdog control 0x28) reads zero.
- R2: Writing 1 to bit 14 of the watchdog control register (0x28) sets the enable bit. A later write of 0 to that bit leaves it at 1. Only the block reset clears it. The bit reads back at bit 14.
- R3: With the watchdog enabled and running, a write to 0x28 whose key field (bits 31:16) holds 0xA5C6 moves the phase from idle (0) to pre-active (1). A following key of 0xDA7E moves it to active (2). In pre-active, any key other than those two returns the phase to idle. In idle, keys other than 0xA5C6 are ignored. The phase reads back at bits 13:12 of 0x28. Key writes are checked against the enable bit as it stood before the write.
- R4: The watchdog runs only when the global control register (0x24) has its mode field (bits 3:2) at 2 and both release bits (bits 1:0) at 1. Otherwise key writes have no effect on the phase.
- R5: In the active phases (2 and 3), the 64-bit counter increments by one every cycle, carrying from the lower word into the upper word.
- R6: When the counter equals the period in an active phase, a trip occurs on that clock edge. On a trip, the timeout flag is set, the phase returns to idle, the counter is cleared to zero, and the enable bit stays set.
- R7: In the active phase (2), a key other than 0xA5C6 trips at once. In the service phase (3, reached by 0xA5C6 from active), any key other than 0xDA7E trips at once. The trip happens on the clock edge that takes the write.
- R8: In the service phase, a key of 0xDA7E clears the counter to zero and returns to the active phase without a trip. The next timeout then lands period+1 cycles after that write.
- R9: `wd_rst_req` goes high in the cycle after the trip edge and stays high for exactly PULSE_LEN cycles (4 by default).
- R10: The timeout flag reads at bit 15 of 0x28. It stays set until a write to 0x28 with bit 15 at 1 clears it. A write with bit 15 at 0 leaves it set.
- R11: While the phase is active or service, writes to 0x10, 0x14, 0x18, 0x1C and 0x24 are ignored.
- R12: Reading the lower counter word (0x10) captures the upper word at that moment. A later read of 0x14 returns the captured value, not the live upper word.
- R13: A read strobe returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the strobe. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| wd_rst_req | output | 1 | Registered reset request pulse |

The register bus has no back-pressure. The block takes every strobe in the cycle it is given, so no ready signal is needed.

## Verification
The bench aims at the exact timeout edge. With a period of 10, the request must still be low 10 cycles after the last arming or service write and high one cycle later. A design that compared after incrementing, or cleared one cycle late, would fire one cycle early or late. The bench also writes wrong keys in both active phases and expects the request the very next cycle. A design that silently ignored a bad key there would never reset. It tries to clear the enable bit, reprogram the period and change the mode while active. A design missing the lock would read back the new values. Finally, it preloads the counter just below a 32-bit wrap and reads the upper word after the wrap. A design without the snapshot would return the live upper word of 1 instead of the captured 0.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ACT  = 2'd2,
    PH_SVC  = 2'd3
  } wd_phase_e;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_GCTL   = 8'h24;
  localparam logic [7:0] OFS_WCTL   = 8'h28;

  localparam logic [1:0] MODE_WATCHDOG = 2'd2;

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY_A = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_B = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             armed,
  input  logic             timeout,
  output wd_phase_e        phase,
  output logic             svc_ok,
  output logic             key_bad
);

  wd_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    svc_ok  = 1'b0;
    key_bad = 1'b0;
    if (key_wr && armed) begin
      unique case (phase_q)
        PH_IDLE: if (key == KEY_A) phase_d = PH_PRE;
        PH_PRE: begin
          if (key == KEY_B)      phase_d = PH_ACT;
          else if (key != KEY_A) phase_d = PH_IDLE;
        end
        PH_ACT: begin
          if (key == KEY_A) phase_d = PH_SVC;
          else              key_bad = 1'b1;
        end
        PH_SVC: begin
          if (key == KEY_B) begin
            phase_d = PH_ACT;
            svc_ok  = 1'b1;
          end else begin
            key_bad = 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
    if (timeout || key_bad) phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BUS_W = 32,
  parameter int NW    = 2,
  localparam int CNT_W = BUS_W * NW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    cnt_wr,
  input  logic [NW-1:0]    prd_wr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             count_en,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd,
  output logic             hit
);

  logic [BUS_W-1:0] cnt_w [NW];
  logic [BUS_W-1:0] prd_w [NW];
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      cnt[i*BUS_W +: BUS_W] = cnt_w[i];
      prd[i*BUS_W +: BUS_W] = prd_w[i];
    end
  end

  assign cnt_inc = cnt + CNT_W'(1);
  assign hit     = count_en && (cnt == prd);

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_w[w] <= '0;
      else if (clear)      cnt_w[w] <= '0;
      else if (count_en)   cnt_w[w] <= cnt_inc[w*BUS_W +: BUS_W];
      else if (cnt_wr[w])  cnt_w[w] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prd_w[w] <= '0;
      else if (prd_wr[w])  prd_w[w] <= wdata;
    end
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 4,
  localparam int PC_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  logic [PC_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      pulse  <= 1'b0;
    end else if (fire) begin
      left_q <= PC_W'(PULSE_LEN);
      pulse  <= 1'b1;
    end else begin
      if (left_q != '0) left_q <= left_q - PC_W'(1);
      pulse <= (left_q > PC_W'(1));
    end
  end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 6,
  parameter int PULSE_LEN = 4,
  parameter logic [15:0] KEY_A = 16'hA5C6,
  parameter logic [15:0] KEY_B = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              wd_rst_req
);

  localparam int NW    = 2;
  localparam int CNT_W = BUS_W * NW;
  localparam int EN_B  = 14;
  localparam int FL_B  = 15;
  localparam int KEY_L = 16;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_PRD_LO = ADDR_W'(OFS_PRD_LO);
  localparam logic [ADDR_W-1:0] A_PRD_HI = ADDR_W'(OFS_PRD_HI);
  localparam logic [ADDR_W-1:0] A_GCTL   = ADDR_W'(OFS_GCTL);
  localparam logic [ADDR_W-1:0] A_WCTL   = ADDR_W'(OFS_WCTL);

  logic              en_q, flag_q;
  logic [1:0]        mode_q, rel_q;
  logic [BUS_W-1:0]  snap_q;
  logic [BUS_W-1:0]  rdata_q, rmux;
  logic              rvalid_q;

  wd_phase_e         phase;
  logic              svc_ok, key_bad, hit, trip, run, locked;
  logic              wctl_wr;
  logic [NW-1:0]     cnt_wr, prd_wr;
  logic [CNT_W-1:0]  cnt_val, prd_val;

  assign run     = (mode_q == MODE_WATCHDOG) && (rel_q == 2'b11);
  assign locked  = (phase == PH_ACT) || (phase == PH_SVC);
  assign wctl_wr = bus_wr && (bus_addr == A_WCTL);
  assign trip    = hit || key_bad;

  assign cnt_wr[0] = bus_wr && !locked && (bus_addr == A_CNT_LO);
  assign cnt_wr[1] = bus_wr && !locked && (bus_addr == A_CNT_HI);
  assign prd_wr[0] = bus_wr && !locked && (bus_addr == A_PRD_LO);
  assign prd_wr[1] = bus_wr && !locked && (bus_addr == A_PRD_HI);

  wdt_keyseq #(
    .KEY_W (16),
    .KEY_A (KEY_A),
    .KEY_B (KEY_B)
  ) u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wctl_wr),
    .key     (bus_wdata[KEY_L +: 16]),
    .armed   (en_q && run),
    .timeout (hit),
    .phase   (phase),
    .svc_ok  (svc_ok),
    .key_bad (key_bad)
  );

  wdt_count #(
    .BUS_W (BUS_W),
    .NW    (NW)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wr   (cnt_wr),
    .prd_wr   (prd_wr),
    .wdata    (bus_wdata),
    .count_en (locked && run),
    .clear    (trip || svc_ok),
    .cnt      (cnt_val),
    .prd      (prd_val),
    .hit      (hit)
  );

  wdt_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (trip),
    .pulse (wd_rst_req)
  );

  // control and status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      mode_q <= 2'd0;
      rel_q  <= 2'd0;
    end else begin
      if (wctl_wr && bus_wdata[EN_B]) en_q <= 1'b1;
      if (trip)                              flag_q <= 1'b1;
      else if (wctl_wr && bus_wdata[FL_B])   flag_q <= 1'b0;
      if (bus_wr && !locked && (bus_addr == A_GCTL)) begin
        mode_q <= bus_wdata[3:2];
        rel_q  <= bus_wdata[1:0];
      end
    end
  end

  // read path
  always_comb begin
    rmux = '0;
    unique case (bus_addr)
      A_CNT_LO: rmux = cnt_val[BUS_W-1:0];
      A_CNT_HI: rmux = snap_q;
      A_PRD_LO: rmux = prd_val[BUS_W-1:0];
      A_PRD_HI: rmux = prd_val[CNT_W-1:BUS_W];
      A_GCTL:   rmux = BUS_W'({mode_q, rel_q});
      A_WCTL:   rmux = BUS_W'({flag_q, en_q, phase, 12'h000});
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rmux;
      if (bus_rd && (bus_addr == A_CNT_LO)) snap_q <= cnt_val[CNT_W-1:BUS_W];
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int PULSE_LEN = 4,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 64,
  localparam int RUN_W    = $clog2(PULSE_LEN + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req,
  input logic              en,
  input logic              flag,
  input logic [1:0]        phase,
  input logic              locked,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  prd
);

  logic [RUN_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (rst_req) hi_run <= hi_run + RUN_W'(1);
    else              hi_run <= '0;
  end

  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(en));

  // R3
  no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |=> (phase[1] == 1'b0));

  // R6
  flag_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> flag);

  // R7
  trip_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(phase[1]) && phase == 2'd0));

  // R9
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (hi_run < RUN_W'(PULSE_LEN)));

  // R9
  pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_run == RUN_W'(PULSE_LEN)));

  // R11
  prd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && (bus_addr == ADDR_W'(8'h18) || bus_addr == ADDR_W'(8'h1C)))
      |=> $stable(prd));

endmodule

bind wdt_top wdt_chk #(
  .PULSE_LEN (PULSE_LEN),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_req  (wd_rst_req),
  .en       (en_q),
  .flag     (flag_q),
  .phase    (phase),
  .locked   (locked),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .prd      (prd_val)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

  localparam int PL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        wd_rst_req;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wdt_top #(.PULSE_LEN(PL)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .wd_rst_req (wd_rst_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic arm(input logic [63:0] prd, input logic [63:0] cnt);
    wr(6'h10, cnt[31:0]);
    wr(6'h14, cnt[63:32]);
    wr(6'h18, prd[31:0]);
    wr(6'h1C, prd[63:32]);
    wr(6'h24, 32'h0000_000B);
    wr(6'h28, 32'h0000_4000);
    wr(6'h28, 32'hA5C6_4000);
    wr(6'h28, 32'hDA7E_4000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 rst_req", 64'(wd_rst_req), 64'd0);
    rd(6'h28, d); check("R1 wctl", 64'(d), 64'd0);
    rd(6'h10, d); check("R1 cnt lo", 64'(d), 64'd0);
    rd(6'h1C, d); check("R1 prd hi", 64'(d), 64'd0);
    rd(6'h24, d); check("R1 gctl", 64'(d), 64'd0);
    check("R13 rvalid after read", 64'(bus_rvalid), 64'd1);
    rd(6'h3C, d); check("R13 unmapped", 64'(d), 64'd0);
  endtask

  task automatic t_handshake();
    logic [31:0] d;
    do_reset();
    wr(6'h18, 32'd1000);
    wr(6'h28, 32'h0000_4000);
    rd(6'h28, d); check("R2 enable set", 64'(d), 64'h4000);
    wr(6'h28, 32'hA5C6_4000);
    rd(6'h28, d); check("R4 key ignored mode 0", 64'(d), 64'h4000);
    wr(6'h24, 32'h0000_0009);
    wr(6'h28, 32'hA5C6_0000);
    rd(6'h28, d); check("R4 key ignored half in reset", 64'(d), 64'h4000);
    wr(6'h28, 32'h0000_0000);
    rd(6'h28, d); check("R2 enable sticky", 64'(d), 64'h4000);
    wr(6'h24, 32'h0000_000B);
    rd(6'h24, d); check("R4 gctl readback", 64'(d), 64'hB);
    wr(6'h28, 32'h1234_0000);
    rd(6'h28, d); check("R3 idle ignores other key", 64'(d), 64'h4000);
    wr(6'h28, 32'hA5C6_0000);
    rd(6'h28, d); check("R3 pre-active", 64'(d), 64'h5000);
    wr(6'h28, 32'h1111_0000);
    rd(6'h28, d); check("R3 pre-active falls back", 64'(d), 64'h4000);
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h28, 32'hDA7E_0000);
    rd(6'h28, d); check("R3 active", 64'(d), 64'h6000);
    wr(6'h28, 32'hA5C6_0000);
    rd(6'h28, d); check("R8 service phase", 64'(d), 64'h7000);
    wr(6'h28, 32'hDA7E_0000);
    rd(6'h28, d); check("R8 back to active", 64'(d), 64'h6000);
    check("R8 no trip", 64'(wd_rst_req), 64'd0);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    do_reset();
    arm(64'd10, 64'd0);
    repeat (10) @(negedge clk);
    check("R6 not yet at period", 64'(wd_rst_req), 64'd0);
    @(negedge clk);
    check("R6 trip at period", 64'(wd_rst_req), 64'd1);
    for (int i = 1; i < PL; i++) begin
      @(negedge clk);
      check("R9 pulse held", 64'(wd_rst_req), 64'd1);
    end
    @(negedge clk);
    check("R9 pulse ends", 64'(wd_rst_req), 64'd0);
    rd(6'h28, d); check("R6 flag set idle enabled", 64'(d), 64'hC000);
    rd(6'h10, d); check("R6 counter cleared", 64'(d), 64'd0);
    wr(6'h28, 32'h0000_4000);
    rd(6'h28, d); check("R10 flag kept on 0", 64'(d), 64'hC000);
    wr(6'h28, 32'h0000_8000);
    rd(6'h28, d); check("R10 flag cleared by 1", 64'(d), 64'h4000);
  endtask

  task automatic t_badkey();
    logic [31:0] d;
    do_reset();
    arm(64'd1000, 64'd0);
    wr(6'h28, 32'h0000_4000);
    check("R7 bad key in active", 64'(wd_rst_req), 64'd1);
    rd(6'h28, d); check("R7 flag after bad key", 64'(d), 64'hC000);
    do_reset();
    arm(64'd1000, 64'd0);
    wr(6'h28, 32'hA5C6_0000);
    check("R7 first service key no trip", 64'(wd_rst_req), 64'd0);
    wr(6'h28, 32'hA5C6_0000);
    check("R7 bad key in service", 64'(wd_rst_req), 64'd1);
  endtask

  task automatic t_service();
    do_reset();
    arm(64'd10, 64'd0);
    repeat (5) @(negedge clk);
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h28, 32'hDA7E_0000);
    repeat (10) @(negedge clk);
    check("R8 restarted count no trip", 64'(wd_rst_req), 64'd0);
    @(negedge clk);
    check("R8 trip after restart", 64'(wd_rst_req), 64'd1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    do_reset();
    arm(64'd1000, 64'd0);
    wr(6'h18, 32'd3);
    wr(6'h24, 32'd0);
    wr(6'h14, 32'h5);
    rd(6'h18, d); check("R11 period locked", 64'(d), 64'd1000);
    rd(6'h24, d); check("R11 gctl locked", 64'(d), 64'hB);
    rd(6'h10, d);
    rd(6'h14, d); check("R11 counter hi locked", 64'(d), 64'd0);
    check("R11 still running", 64'(wd_rst_req), 64'd0);
  endtask

  task automatic t_snapshot();
    logic [31:0] d;
    do_reset();
    arm({32'd5, 32'd0}, {32'd0, 32'hFFFF_FFF0});
    rd(6'h10, d); check("R5 lo at start", 64'(d), 64'hFFFF_FFF0);
    repeat (20) @(negedge clk);
    rd(6'h14, d); check("R12 hi from snapshot", 64'(d), 64'd0);
    rd(6'h10, d); check("R5 lo wrapped", 64'(d < 32'h100), 64'd1);
    rd(6'h14, d); check("R5 R12 carry into hi", 64'(d), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_handshake();
    t_timeout();
    t_badkey();
    t_service();
    t_lock();
    t_snapshot();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule